// File: doc/BRIEF.md
# Multi-Channel DAC Register Front End

This block is the digital side of an eight-channel, 10-bit converter. A host writes it over a parallel bus with a chip select, a write strobe, a control-or-data flag, a channel address and ten data lines. It keeps one system configuration register and, for each channel, a configuration register, a main-DAC input register and a sub-DAC input register. The host can use the full 10-bit bus. In byte mode it uses only the upper eight data lines and turns the two lowest lines into selectors. A load strobe moves the input registers into the output code registers that feed the analog cores. Three clear paths force those codes to defined values: an external pin, a one-shot software command and a per-channel flag.

The host port is run by a small state machine. `HOST_IDLE` waits for chip select and write strobe to be low together. It then captures the bus and moves to `HOST_COMMIT` (transition *accept*). `HOST_COMMIT` applies the decoded write for exactly one cycle. From there it goes to `HOST_RELEASE` if the strobe is still held (transition *hold*), or back to `HOST_IDLE` if it is not (transition *done*). `HOST_RELEASE` returns to `HOST_IDLE` once the strobe is released (transition *release*). Each strobe therefore makes exactly one register write. The write lands on the second rising edge after the strobe is first sampled low.

Output codes are straight binary. When two's-complement coding is selected, the transfer inverts the code MSB. Bias-select bits are only stored and exported.

Top module: `dac_regif`

## Requirements
- R1: After reset the system register has power-down=1, system standby=1, 10-bit mode and offset-binary coding. Every main output code is 0, every sub output code is 512 (0x200), `power_down_o`=1 and `ch_standby_o` is all ones.
- R2: After reset every channel register has standby=1, clear=1, bias=00 and main selected. A system write that takes the system out of standby therefore leaves every `ch_standby_o` bit high.
- R3: A write happens only when `host_cs_n` and `host_wr_n` are sampled low together. Its effect is visible after the second rising edge. A strobe with `host_cs_n` high changes nothing.
- R4: A control write (`host_ctl`=1) goes to the system register when `host_data[0]`=0 and to the addressed channel register when `host_data[0]`=1, in both bus modes; `host_data[1]` is ignored. System fields: bit 9 byte mode, bit 8 two's complement, bit 7 software clear, bit 6 system standby, bit 5 power-down. Channel fields: bit 9 sub select, bit 8 standby, bit 7 clear, bits 6:5 bias.
- R5: In 10-bit mode a data write (`host_ctl`=0) loads all ten bits into the addressed channel's sub input register if its sub-select bit is 1, and into its main input register otherwise.
- R6: In byte mode a data write targets the sub register when `host_data[0]`=1 and the main register when it is 0, regardless of the sub-select bit. With `host_data[1]`=0, `host_data[9:2]` loads code bits 9:2. With `host_data[1]`=1, `host_data[9:8]` loads code bits 1:0. The other half is kept.
- R7: Output codes change only on a load (`ldac_n` low at a rising edge) or a clear. A load copies every input register to its output, inverting bit 9 under two's complement.
- R8: On a load, a channel whose clear bit is 1 gets the main clear code (512 in two's complement, 0 in offset binary) instead of its main input. Its sub output still loads normally.
- R9: Writing the software-clear bit sets every main output to the main clear code on the write's commit edge, without a load. Sub outputs are untouched and the bit is not stored.
- R10: While `ext_clr_n` is low, every main output holds the main clear code for the current coding and every sub output holds 512. Loads are ignored. After release the codes stay cleared until the next load.
- R11: `power_down_o` mirrors the power-down bit. `ch_standby_o[i]` is high when power-down, system standby or channel i's standby bit is set.
- R12: `bias_sel_o[2i+1:2i]` shows channel i's stored bias bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| host_cs_n | input | 1 | Active-low chip select |
| host_wr_n | input | 1 | Active-low write strobe |
| host_ctl | input | 1 | 1 = control register access, 0 = data register access |
| host_addr | input | ADDR_W | Channel address |
| host_data | input | 10 | Write data |
| ldac_n | input | 1 | Active-low load strobe |
| ext_clr_n | input | 1 | Active-low external clear |
| main_code_o | output | NUM_CH*10 | Main DAC output codes, channel i at bits 10i+9:10i |
| sub_code_o | output | NUM_CH*10 | Sub DAC output codes, same packing |
| bias_sel_o | output | NUM_CH*2 | Stored bias-select bits per channel |
| ch_standby_o | output | NUM_CH | Per-channel low-power flag |
| power_down_o | output | 1 | System power-down flag |

## Verification
A wrong host-state machine state either drops a write or repeats one. That shows at the ports on the first load after the write, as a stale code or an unexpected half-byte. Corrupt configuration bits show up in `ch_standby_o` and `bias_sel_o` on the cycle after the commit edge. Wrong coding or clear-select bits appear as a flipped MSB or a wrong clear value on the next load or clear. A clear path with the wrong scope shows in the same cycle as the clear: main and sub outputs are compared together after every software and external clear, so a sub output that moves, or a main output that fails to move, is caught at once.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam int CODE_W = 10;
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // control register field positions inside host_data
    localparam int SYS_BYTE_BIT = 9;
    localparam int SYS_TWOS_BIT = 8;
    localparam int SYS_SCLR_BIT = 7;
    localparam int SYS_STBY_BIT = 6;
    localparam int SYS_PD_BIT   = 5;
    localparam int CH_SUB_BIT   = 9;
    localparam int CH_STBY_BIT  = 8;
    localparam int CH_CLR_BIT   = 7;
    localparam int CH_BIAS_HI   = 6;
    localparam int CH_BIAS_LO   = 5;
    localparam int REG_SEL_BIT  = 0;   // control: 0 system, 1 channel; byte-mode data: 0 main, 1 sub
    localparam int HALF_BIT     = 1;   // byte-mode data: 0 upper eight bits, 1 lower two bits
    localparam int LO_W         = 2;

    typedef enum logic [1:0] {
        HOST_IDLE    = 2'd0,
        HOST_COMMIT  = 2'd1,
        HOST_RELEASE = 2'd2
    } host_state_e;

    typedef struct packed {
        logic byte_mode;
        logic twos;
        logic sys_stby;
        logic pdown;
    } sys_cfg_t;

    typedef struct packed {
        logic       sub_sel;
        logic       stby;
        logic       clr;
        logic [1:0] bias;
    } ch_cfg_t;

    localparam sys_cfg_t SYS_RESET = '{byte_mode: 1'b0, twos: 1'b0, sys_stby: 1'b1, pdown: 1'b1};
    localparam ch_cfg_t  CH_RESET  = '{sub_sel: 1'b0, stby: 1'b1, clr: 1'b1, bias: 2'b00};

    function automatic logic [CODE_W-1:0] main_clear_code(input logic twos);
        return twos ? MID_CODE : '0;
    endfunction

    function automatic logic [CODE_W-1:0] to_dac_code(input logic [CODE_W-1:0] v, input logic twos);
        return twos ? (v ^ MID_CODE) : v;
    endfunction

endpackage

// File: rtl/dac_regif_host.sv
module dac_regif_host
    import dac_regif_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] data,
    output logic              commit_o,
    output logic              cap_ctl_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [CODE_W-1:0] cap_data_o
);

    host_state_e state_q, state_d;
    logic        strobe;

    assign strobe = !cs_n && !wr_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOST_IDLE:    if (strobe)  state_d = HOST_COMMIT;
            HOST_COMMIT:  state_d = strobe ? HOST_RELEASE : HOST_IDLE;
            HOST_RELEASE: if (!strobe) state_d = HOST_IDLE;
            default:      state_d = HOST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = (state_q == HOST_COMMIT);
    end

    // bus capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ctl_o  <= 1'b0;
            cap_addr_o <= '0;
            cap_data_o <= '0;
        end else if (state_q == HOST_IDLE && strobe) begin
            cap_ctl_o  <= ctl;
            cap_addr_o <= addr;
            cap_data_o <= data;
        end
    end

endmodule

// File: rtl/dac_regif_sysreg.sv
module dac_regif_sysreg
    import dac_regif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  sys_cfg_t wr_cfg,
    input  logic     wr_sclr,
    output sys_cfg_t cfg_o,
    output logic     sclr_fire_o
);

    sys_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= SYS_RESET;
        end else if (wr_en) begin
            cfg_q <= wr_cfg;
        end
    end

    // software clear is a one-shot command, never stored
    assign sclr_fire_o = wr_en && wr_sclr;
    assign cfg_o       = cfg_q;

endmodule

// File: rtl/dac_regif_chan.sv
module dac_regif_chan
    import dac_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  ch_cfg_t           ctl_wcfg,
    input  logic              data_we,
    input  logic              byte_mode,
    input  logic [CODE_W-1:0] wdata,
    input  logic              twos,
    input  logic              ldac,
    input  logic              ext_clr,
    input  logic              sw_clr,
    output logic              stby_o,
    output logic [1:0]        bias_o,
    output logic [CODE_W-1:0] main_code_o,
    output logic [CODE_W-1:0] sub_code_o
);

    ch_cfg_t           cfg_q;
    logic [CODE_W-1:0] main_in_q, sub_in_q;
    logic [CODE_W-1:0] main_out_q, sub_out_q;
    logic              tgt_sub;
    logic [CODE_W-1:0] cur_val, load_val, clr_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CH_RESET;
        end else if (ctl_we) begin
            cfg_q <= ctl_wcfg;
        end
    end

    // target and merged value of a data write
    always_comb begin
        tgt_sub  = byte_mode ? wdata[REG_SEL_BIT] : cfg_q.sub_sel;
        cur_val  = tgt_sub ? sub_in_q : main_in_q;
        load_val = wdata;
        if (byte_mode) begin
            if (wdata[HALF_BIT]) begin
                load_val = {cur_val[CODE_W-1:LO_W], wdata[CODE_W-1 -: LO_W]};
            end else begin
                load_val = {wdata[CODE_W-1:LO_W], cur_val[LO_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_in_q <= '0;
            sub_in_q  <= '0;
        end else if (data_we) begin
            if (tgt_sub) begin
                sub_in_q <= load_val;
            end else begin
                main_in_q <= load_val;
            end
        end
    end

    assign clr_code = main_clear_code(twos);

    // output codes: external clear > software clear > load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_out_q <= '0;
            sub_out_q  <= MID_CODE;
        end else if (ext_clr) begin
            main_out_q <= clr_code;
            sub_out_q  <= MID_CODE;
        end else begin
            if (sw_clr) begin
                main_out_q <= clr_code;
            end else if (ldac) begin
                main_out_q <= cfg_q.clr ? clr_code : to_dac_code(main_in_q, twos);
            end
            if (ldac) begin
                sub_out_q <= to_dac_code(sub_in_q, twos);
            end
        end
    end

    assign stby_o      = cfg_q.stby;
    assign bias_o      = cfg_q.bias;
    assign main_code_o = main_out_q;
    assign sub_code_o  = sub_out_q;

endmodule

// File: rtl/dac_regif.sv
module dac_regif
    import dac_regif_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NUM_CH = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_cs_n,
    input  logic                       host_wr_n,
    input  logic                       host_ctl,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [CODE_W-1:0]          host_data,
    input  logic                       ldac_n,
    input  logic                       ext_clr_n,
    output logic [NUM_CH*CODE_W-1:0]   main_code_o,
    output logic [NUM_CH*CODE_W-1:0]   sub_code_o,
    output logic [NUM_CH*2-1:0]        bias_sel_o,
    output logic [NUM_CH-1:0]          ch_standby_o,
    output logic                       power_down_o
);

    logic              commit;
    logic              cap_ctl;
    logic [ADDR_W-1:0] cap_addr;
    logic [CODE_W-1:0] cap_data;
    sys_cfg_t          sys_cfg, sys_wcfg;
    ch_cfg_t           ch_wcfg;
    logic              sys_we;
    logic              sclr_fire;
    logic              twos_mode;

    dac_regif_host #(.ADDR_W(ADDR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (host_cs_n),
        .wr_n       (host_wr_n),
        .ctl        (host_ctl),
        .addr       (host_addr),
        .data       (host_data),
        .commit_o   (commit),
        .cap_ctl_o  (cap_ctl),
        .cap_addr_o (cap_addr),
        .cap_data_o (cap_data)
    );

    assign sys_we   = commit && cap_ctl && !cap_data[REG_SEL_BIT];
    assign sys_wcfg = '{byte_mode: cap_data[SYS_BYTE_BIT],
                        twos:      cap_data[SYS_TWOS_BIT],
                        sys_stby:  cap_data[SYS_STBY_BIT],
                        pdown:     cap_data[SYS_PD_BIT]};
    assign ch_wcfg  = '{sub_sel: cap_data[CH_SUB_BIT],
                        stby:    cap_data[CH_STBY_BIT],
                        clr:     cap_data[CH_CLR_BIT],
                        bias:    cap_data[CH_BIAS_HI:CH_BIAS_LO]};

    dac_regif_sysreg u_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (sys_we),
        .wr_cfg      (sys_wcfg),
        .wr_sclr     (cap_data[SYS_SCLR_BIT]),
        .cfg_o       (sys_cfg),
        .sclr_fire_o (sclr_fire)
    );

    assign twos_mode    = sys_cfg.twos;
    assign power_down_o = sys_cfg.pdown;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] CH_ID = ADDR_W'(i);
        logic hit, ch_stby;

        assign hit = (cap_addr == CH_ID);

        dac_regif_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctl_we      (commit && cap_ctl && cap_data[REG_SEL_BIT] && hit),
            .ctl_wcfg    (ch_wcfg),
            .data_we     (commit && !cap_ctl && hit),
            .byte_mode   (sys_cfg.byte_mode),
            .wdata       (cap_data),
            .twos        (sys_cfg.twos),
            .ldac        (!ldac_n),
            .ext_clr     (!ext_clr_n),
            .sw_clr      (sclr_fire),
            .stby_o      (ch_stby),
            .bias_o      (bias_sel_o[2*i +: 2]),
            .main_code_o (main_code_o[i*CODE_W +: CODE_W]),
            .sub_code_o  (sub_code_o[i*CODE_W +: CODE_W])
        );

        assign ch_standby_o[i] = sys_cfg.pdown || sys_cfg.sys_stby || ch_stby;
    end

endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk
    import dac_regif_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_cs_n,
    input logic                     host_wr_n,
    input logic                     ldac_n,
    input logic                     ext_clr_n,
    input logic [NUM_CH*CODE_W-1:0] main_code,
    input logic [NUM_CH*CODE_W-1:0] sub_code,
    input logic [NUM_CH-1:0]        ch_standby,
    input logic                     power_down,
    input logic                     commit,
    input logic                     sclr_fire,
    input logic                     twos
);

    // R3: a commit cycle always follows an accepted strobe
    p_commit_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!host_cs_n && !host_wr_n));

    // R7: with no load and no clear, outputs hold
    p_hold_without_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_n && ext_clr_n && !sclr_fire) |=> ($stable(main_code) && $stable(sub_code)));

    // R9: a software clear leaves sub outputs alone
    p_swclr_sub_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclr_fire && ldac_n && ext_clr_n) |=> $stable(sub_code));

    // R11: power-down puts every channel in standby
    p_pd_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (&ch_standby));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R10: external clear values
        p_extclr_sub_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ext_clr_n |=> (sub_code[c*CODE_W +: CODE_W] == MID_CODE));
        p_extclr_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ext_clr_n |=> (main_code[c*CODE_W +: CODE_W] == ($past(twos) ? MID_CODE : '0)));
        // R9: software clear value on every main output
        p_swclr_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sclr_fire && ext_clr_n) |=> (main_code[c*CODE_W +: CODE_W] == ($past(twos) ? MID_CODE : '0)));
    end

endmodule

bind dac_regif dac_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs_n  (host_cs_n),
    .host_wr_n  (host_wr_n),
    .ldac_n     (ldac_n),
    .ext_clr_n  (ext_clr_n),
    .main_code  (main_code_o),
    .sub_code   (sub_code_o),
    .ch_standby (ch_standby_o),
    .power_down (power_down_o),
    .commit     (commit),
    .sclr_fire  (sclr_fire),
    .twos       (twos_mode)
);

// File: tb/dac_regif_tb_top.sv
module dac_regif_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 3;
    localparam int NUM_CH     = 8;
    localparam int W          = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_cs_n = 1'b1;
    logic              host_wr_n = 1'b1;
    logic              host_ctl = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [W-1:0]      host_data = '0;
    logic              ldac_n = 1'b1;
    logic              ext_clr_n = 1'b1;
    logic [NUM_CH*W-1:0] main_code_o, sub_code_o;
    logic [NUM_CH*2-1:0] bias_sel_o;
    logic [NUM_CH-1:0]   ch_standby_o;
    logic                power_down_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         req;
        int         ch;
        logic [W-1:0] m;
        logic [W-1:0] s;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_regif #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_cs_n    (host_cs_n),
        .host_wr_n    (host_wr_n),
        .host_ctl     (host_ctl),
        .host_addr    (host_addr),
        .host_data    (host_data),
        .ldac_n       (ldac_n),
        .ext_clr_n    (ext_clr_n),
        .main_code_o  (main_code_o),
        .sub_code_o   (sub_code_o),
        .bias_sel_o   (bias_sel_o),
        .ch_standby_o (ch_standby_o),
        .power_down_o (power_down_o)
    );

    // monitor: pops expected codes and compares them with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [W-1:0] am, as;
            e  = exp_q.pop_front();
            am = main_code_o[e.ch*W +: W];
            as = sub_code_o[e.ch*W +: W];
            checks++;
            if (am !== e.m || as !== e.s) begin
                fails++;
                $display("FAIL R%0d ch%0d main=%h sub=%h expected main=%h sub=%h",
                         e.req, e.ch, am, as, e.m, e.s);
            end
        end
    end

    task automatic expect_codes(input int req, input int ch, input logic [W-1:0] m, input logic [W-1:0] s);
        exp_t e;
        e.req = req; e.ch = ch; e.m = m; e.s = s;
        #1;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic ctl, input int ch, input logic [W-1:0] d);
        @(negedge clk);
        host_cs_n = 1'b0; host_wr_n = 1'b0; host_ctl = ctl;
        host_addr = ADDR_W'(ch); host_data = d;
        @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_ldac();
        @(negedge clk);
        ldac_n = 1'b0;
        @(negedge clk);
        ldac_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 reset state
        expect_codes(1, 0, 10'h000, 10'h200);
        expect_codes(1, 7, 10'h000, 10'h200);
        check_val("R1 power_down", 32'(power_down_o), 32'h1);
        check_val("R1 ch_standby", 32'(ch_standby_o), 32'hFF);
        check_val("R2 bias reset", 32'(bias_sel_o), 32'h0);

        // R2 R11 leave system standby; channels stay in standby
        host_write(1'b1, 0, 10'h000);
        check_val("R11 power_down cleared", 32'(power_down_o), 32'h0);
        check_val("R2 ch_standby after system wake", 32'(ch_standby_o), 32'hFF);

        // R4 R12 channel 3: main, awake, no clear, bias 10
        host_write(1'b1, 3, 10'h041);
        check_val("R4 ch3 standby", 32'(ch_standby_o), 32'hF7);
        check_val("R12 ch3 bias", 32'(bias_sel_o[7:6]), 32'h2);

        // R5 R7 double-buffered main write
        host_write(1'b0, 3, 10'h2A5);
        expect_codes(7, 3, 10'h000, 10'h200);
        pulse_ldac();
        expect_codes(5, 3, 10'h2A5, 10'h000);
        expect_codes(8, 0, 10'h000, 10'h000);

        // R5 sub select in 10-bit mode
        host_write(1'b1, 3, 10'h241);
        host_write(1'b0, 3, 10'h155);
        pulse_ldac();
        expect_codes(5, 3, 10'h2A5, 10'h155);

        // R7 R8 two's complement coding
        host_write(1'b1, 0, 10'h100);
        pulse_ldac();
        expect_codes(7, 3, 10'h0A5, 10'h355);
        expect_codes(8, 0, 10'h200, 10'h200);

        // R9 software clear acts without a load, subs kept
        host_write(1'b1, 0, 10'h180);
        expect_codes(9, 3, 10'h200, 10'h355);
        pulse_ldac();
        expect_codes(9, 3, 10'h0A5, 10'h355);

        // R8 per-channel clear hits only flagged channels
        host_write(1'b1, 5, 10'h001);
        host_write(1'b0, 5, 10'h123);
        host_write(1'b1, 3, 10'h2C1);
        pulse_ldac();
        expect_codes(8, 3, 10'h200, 10'h355);
        expect_codes(8, 5, 10'h323, 10'h200);
        check_val("R11 ch_standby mix", 32'(ch_standby_o), 32'hD7);

        // R10 external clear, priority over load, coding-dependent value
        @(negedge clk);
        ext_clr_n = 1'b0;
        @(negedge clk);
        expect_codes(10, 5, 10'h200, 10'h200);
        pulse_ldac();
        expect_codes(10, 3, 10'h200, 10'h200);
        host_write(1'b1, 0, 10'h000);
        expect_codes(10, 5, 10'h000, 10'h200);
        ext_clr_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_codes(10, 5, 10'h000, 10'h200);
        pulse_ldac();
        expect_codes(7, 5, 10'h123, 10'h000);
        expect_codes(8, 3, 10'h000, 10'h155);

        // R6 R4 byte mode: control write with DB1 set, split data writes
        host_write(1'b1, 0, 10'h200);
        host_write(1'b1, 6, 10'h003);
        check_val("R4 ch6 standby via byte-mode control", 32'(ch_standby_o), 32'h97);
        host_write(1'b0, 6, 10'h2CC);
        host_write(1'b0, 6, 10'h202);
        host_write(1'b0, 6, 10'h0F1);
        host_write(1'b0, 6, 10'h103);
        pulse_ldac();
        expect_codes(6, 6, 10'h2CE, 10'h0F1);
        host_write(1'b0, 6, 10'h000);
        pulse_ldac();
        expect_codes(6, 6, 10'h002, 10'h0F1);

        // R3 strobe without chip select is ignored
        @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b0; host_ctl = 1'b0;
        host_addr = 3'd6; host_data = 10'h3FC;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        pulse_ldac();
        expect_codes(3, 6, 10'h002, 10'h0F1);

        // R11 system standby forces all channels low power
        host_write(1'b1, 0, 10'h240);
        check_val("R11 system standby", 32'(ch_standby_o), 32'hFF);
        check_val("R11 power_down stays low", 32'(power_down_o), 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule